// File: doc/BRIEF.md
# Configurable Multifunction Pin Router

This block ties eight general-purpose bidirectional pins to a chip's internal status flags and control strobes. Each pin owns an 8-bit configuration register. The top bit of the register sets the pin's direction. The low seven bits pick one function from a sparse code space.

A pin in output mode enables its driver and shows one of the following: a constant, a divided system clock, a status flag, or an active-reference indicator. A pin in input mode disables its driver. Its level passes through a synchronizer and then drives the internal control line that its code names. When two or more input pins name the same control line, the pin with the lowest index drives that line. The other pins are ignored.

The register write port, the pads and the internal functions lie outside this block. They appear here as plain vectors.

Top module: `mfpin_router`

## Requirements
- R1: While reset is asserted, every configuration register returns to 0x00 (input, code 0). After reset, `pinOe`, `pinOut` and `ctrlOut` are all zero, and the divider counter restarts from zero.
- R2: Bit 7 of a pin's register sets its direction. A value of 1 makes the pin an output and sets its `pinOe` bit. A value of 0 makes it an input: `pinOe` is low, `pinOut` is 0, and the level on `pinIn` never reaches another pin's output.
- R3: In output mode, code 0 drives 0 and code 1 drives 1. Code 2 drives the clock divided by 2^DIV_LOG2, with a 50% duty cycle. The divided clock is low for the first 2^(DIV_LOG2-1) cycles after reset, then toggles every 2^(DIV_LOG2-1) cycles.
- R4: Output status codes map as follows:
  - codes 3..8 select `sysStat[code-3]`;
  - code 11 selects `sysStat[6]`;
  - codes 16..26 select `loopStat[code-16]`;
  - codes 32..35 select `refFault[code-32]`;
  - codes 48..51 select `refValid[code-48]`;
  - code 80 selects `syncPulse`.
- R5: Output code 64+k (k = 0..3) drives 1 exactly when `activeRef` equals k.
- R6: Every output code not listed in R3 to R5 drives 0, for example 9, 10, 12, 27, 81 and 127.
- R7: An input-mode pin drives the `ctrlOut` bit that its code selects:
  - codes 1..5 drive bits 0..4;
  - codes 16..20 drive bits 5..9;
  - codes 32..35 drive bits 10..13;
  - codes 48..51 drive bits 14..17;
  - code 64 drives bit 18, code 65 drives bit 19 and code 69 drives bit 20.

  A pin level driven before a clock edge appears on `ctrlOut` after the second edge, not after the first.
- R8: Input code 68 drives both bit 18 and bit 19 of `ctrlOut`.
- R9: When several input-mode pins select the same `ctrlOut` bit, only the lowest-index pin among them drives it. Code 68 counts as selecting both bit 18 and bit 19.
- R10: A `ctrlOut` bit that no input-mode pin selects is 0. Input code 0 and every input code not listed in R7 or R8 has no effect on `ctrlOut`.
- R11: A cycle with `cfgWe` high writes `cfgData` into the register of pin `cfgSel` at that clock edge. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Pin whose register is written |
| cfgData | input | 8 | Register value: bit 7 sets direction, bits 6:0 hold the code |
| sysStat | input | 7 | System status flags (codes 3..8, 11) |
| loopStat | input | 11 | Loop state flags (codes 16..26) |
| refFault | input | 4 | Per-reference fault flags |
| refValid | input | 4 | Per-reference valid flags |
| activeRef | input | 2 | Index of the active reference |
| syncPulse | input | 1 | Distribution sync pulse |
| pinIn | input | 8 | Levels received from the pads |
| pinOut | output | 8 | Levels driven to the pads |
| pinOe | output | 8 | Per-pin output enable |
| ctrlOut | output | 21 | Routed internal control lines |

## Verification
The bench builds the router with its default parameters, DIV_LOG2 = 5 and SYNC_STAGES = 2. These values make the divided clock's 16-cycle high and low phases short enough to measure directly. They also give a fixed two-edge latency, so the bench can check it at both the first and the second edge. With eight pins, the bench can have pins at both ends of the index range claim one control line, which exercises the priority chain. It can also pair code 68 against the two single-enable codes on different pins.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;
  parameter int MF_PINS   = 8;
  parameter int MF_CODE_W = 7;
  parameter int MF_CFG_W  = MF_CODE_W + 1;
  parameter int MF_SEL_W  = $clog2(MF_PINS);
  parameter int MF_SYS_W  = 7;
  parameter int MF_LOOP_W = 11;
  parameter int MF_REF_N  = 4;
  parameter int MF_ACT_W  = $clog2(MF_REF_N);
  parameter int MF_DEST_N = 21;

  typedef struct packed {
    logic [MF_PINS-1:0]                outMode;
    logic [MF_PINS-1:0][MF_CODE_W-1:0] code;
    logic                              divClk;
  } mf_ctl_t;

  // True when input code selects destination bit d of ctrlOut.
  function automatic logic mfTargets(input logic [MF_CODE_W-1:0] code, input int d);
    int c;
    c = int'(code);
    if (d < 5)       return c == d + 1;
    else if (d < 10) return c == 16 + (d - 5);
    else if (d < 14) return c == 32 + (d - 10);
    else if (d < 18) return c == 48 + (d - 14);
    else if (d == 18) return (c == 64) || (c == 68);
    else if (d == 19) return (c == 65) || (c == 68);
    else if (d == 20) return c == 69;
    return 1'b0;
  endfunction
endpackage

// File: rtl/mfpin_ctrl.sv
module mfpin_ctrl
  import mfpin_pkg::*;
#(
  parameter int DIV_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [MF_SEL_W-1:0] cfgSel,
  input  logic [MF_CFG_W-1:0] cfgData,
  output mf_ctl_t             ctlBus
);
  logic [MF_CFG_W-1:0] cfgReg [MF_PINS];
  logic [DIV_LOG2-1:0] divCnt;

  for (genvar p = 0; p < MF_PINS; p++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgReg[p] <= '0;
      else if (cfgWe && (int'(cfgSel) == p))
        cfgReg[p] <= cfgData;
    end
    assign ctlBus.outMode[p] = cfgReg[p][MF_CFG_W-1];
    assign ctlBus.code[p]    = cfgReg[p][MF_CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign ctlBus.divClk = divCnt[DIV_LOG2-1];
endmodule

// File: rtl/mfpin_datapath.sv
module mfpin_datapath
  import mfpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mf_ctl_t              ctlBus,
  input  logic [MF_SYS_W-1:0]  sysStat,
  input  logic [MF_LOOP_W-1:0] loopStat,
  input  logic [MF_REF_N-1:0]  refFault,
  input  logic [MF_REF_N-1:0]  refValid,
  input  logic [MF_ACT_W-1:0]  activeRef,
  input  logic                 syncPulse,
  input  logic [MF_PINS-1:0]   pinIn,
  output logic [MF_PINS-1:0]   pinOut,
  output logic [MF_PINS-1:0]   pinOe,
  output logic [MF_DEST_N-1:0] ctrlOut
);
  logic [MF_PINS-1:0] syncStage [SYNC_STAGES];
  logic [MF_PINS-1:0] pinSync;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= pinIn;
      else syncStage[s] <= syncStage[(s == 0) ? 0 : s - 1];
    end
  end
  assign pinSync = syncStage[SYNC_STAGES-1];

  for (genvar p = 0; p < MF_PINS; p++) begin : g_out
    logic showVal;
    always_comb begin
      int c;
      c = int'(ctlBus.code[p]);
      showVal = 1'b0;
      if (c == 1)                    showVal = 1'b1;
      else if (c == 2)               showVal = ctlBus.divClk;
      else if (c >= 3 && c <= 8)     showVal = sysStat[3'(c - 3)];
      else if (c == 11)              showVal = sysStat[6];
      else if (c >= 16 && c <= 26)   showVal = loopStat[4'(c - 16)];
      else if (c >= 32 && c <= 35)   showVal = refFault[2'(c - 32)];
      else if (c >= 48 && c <= 51)   showVal = refValid[2'(c - 48)];
      else if (c >= 64 && c <= 67)   showVal = (int'(activeRef) == c - 64);
      else if (c == 80)              showVal = syncPulse;
    end
    assign pinOe[p]  = ctlBus.outMode[p];
    assign pinOut[p] = ctlBus.outMode[p] & showVal;
  end

  // Lowest-index input pin claiming a destination wins.
  always_comb begin
    logic [MF_DEST_N-1:0] claimed;
    claimed = '0;
    ctrlOut = '0;
    for (int p = 0; p < MF_PINS; p++) begin
      for (int d = 0; d < MF_DEST_N; d++) begin
        if (!ctlBus.outMode[p] && !claimed[d] && mfTargets(ctlBus.code[p], d)) begin
          claimed[d] = 1'b1;
          ctrlOut[d] = pinSync[p];
        end
      end
    end
  end
endmodule

// File: rtl/mfpin_router.sv
module mfpin_router
  import mfpin_pkg::*;
#(
  parameter int DIV_LOG2    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [MF_SEL_W-1:0]  cfgSel,
  input  logic [MF_CFG_W-1:0]  cfgData,
  input  logic [MF_SYS_W-1:0]  sysStat,
  input  logic [MF_LOOP_W-1:0] loopStat,
  input  logic [MF_REF_N-1:0]  refFault,
  input  logic [MF_REF_N-1:0]  refValid,
  input  logic [MF_ACT_W-1:0]  activeRef,
  input  logic                 syncPulse,
  input  logic [MF_PINS-1:0]   pinIn,
  output logic [MF_PINS-1:0]   pinOut,
  output logic [MF_PINS-1:0]   pinOe,
  output logic [MF_DEST_N-1:0] ctrlOut
);
  mf_ctl_t ctlBus;

  mfpin_ctrl #(.DIV_LOG2(DIV_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .ctlBus(ctlBus)
  );

  mfpin_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ctlBus(ctlBus), .sysStat(sysStat),
    .loopStat(loopStat), .refFault(refFault), .refValid(refValid),
    .activeRef(activeRef), .syncPulse(syncPulse), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .ctrlOut(ctrlOut)
  );
endmodule

// File: rtl/mfpin_router_chk.sv
module mfpin_router_chk
  import mfpin_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic [MF_SEL_W-1:0]  cfgSel,
  input logic [MF_CFG_W-1:0]  cfgData,
  input logic [MF_PINS-1:0]   pinOut,
  input logic [MF_PINS-1:0]   pinOe,
  input logic [MF_DEST_N-1:0] ctrlOut,
  input mf_ctl_t              ctlBus
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && ctrlOut == '0));

  assert_oe_dir_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (pinOe[$past(cfgSel)] == $past(cfgData[MF_CFG_W-1])));

  assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  assert_div_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlBus.divClk) |=> $stable(ctlBus.divClk));

  assert_unclaimed_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe == '1) |-> (ctrlOut == '0));
endmodule

bind mfpin_router mfpin_router_chk chk (.*);

// File: tb/mfpin_router_test.sv
module mfpin_router_test;
  import mfpin_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [7:0] cfgData = '0;
  logic [6:0] sysStat = '0;
  logic [10:0] loopStat = '0;
  logic [3:0] refFault = '0;
  logic [3:0] refValid = '0;
  logic [1:0] activeRef = '0;
  logic syncPulse = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut, pinOe;
  logic [20:0] ctrlOut;
  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfpin_router #(.DIV_LOG2(5), .SYNC_STAGES(2)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input int pin, input logic [7:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 3'(pin); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic clearAll();
    for (int p = 0; p < 8; p++) writeCfg(p, 8'h00);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 oe", 32'(pinOe), 0);
    check("R1 out", 32'(pinOut), 0);
    check("R1 ctrl", 32'(ctrlOut), 0);
  endtask

  task automatic testConstants();
    writeCfg(3, 8'h81);
    check("R2 oe set", 32'(pinOe), 32'h08);
    check("R3 const1", 32'(pinOut), 32'h08);
    writeCfg(3, 8'h80);
    check("R3 const0", 32'(pinOut), 0);
    writeCfg(3, 8'h01);
    check("R2 input oe low", 32'(pinOe), 0);
    check("R2 input out low", 32'(pinOut), 0);
  endtask

  task automatic testStatus();
    writeCfg(0, 8'h80 | 8'd5);   // sysStat[2]
    writeCfg(1, 8'h80 | 8'd11);  // sysStat[6]
    writeCfg(2, 8'h80 | 8'd20);  // loopStat[4]
    writeCfg(3, 8'h80 | 8'd34);  // refFault[2]
    writeCfg(4, 8'h80 | 8'd49);  // refValid[1]
    writeCfg(5, 8'h80 | 8'd80);  // syncPulse
    writeCfg(6, 8'h80 | 8'd26);  // loopStat[10]
    writeCfg(7, 8'h80 | 8'd3);   // sysStat[0]
    @(negedge clk);
    sysStat = 7'b1000100; loopStat = 11'b00000010000; refFault = 4'b0100;
    refValid = 4'b0010; syncPulse = 1'b1;
    #1 check("R4 pattern A", 32'(pinOut), 32'h3F);
    sysStat = 7'b0111011; loopStat = 11'b10000000000; refFault = 4'b1011;
    refValid = 4'b1101; syncPulse = 1'b0;
    #1 check("R4 pattern B", 32'(pinOut), 32'hC0);
    sysStat = '1; loopStat = '1; refFault = '1; refValid = '1; syncPulse = 1'b1;
    writeCfg(0, 8'h80 | 8'd9);
    writeCfg(1, 8'h80 | 8'd10);
    writeCfg(2, 8'h80 | 8'd12);
    writeCfg(3, 8'h80 | 8'd27);
    writeCfg(4, 8'h80 | 8'd36);
    writeCfg(5, 8'h80 | 8'd81);
    writeCfg(6, 8'h80 | 8'd127);
    writeCfg(7, 8'h80 | 8'd68);
    check("R6 unused outputs", 32'(pinOut), 0);
    sysStat = '0; loopStat = '0; refFault = '0; refValid = '0; syncPulse = 1'b0;
  endtask

  task automatic testActiveRef();
    for (int p = 0; p < 4; p++) writeCfg(p, 8'h80 | 8'(64 + p));
    for (int k = 0; k < 4; k++) begin
      activeRef = 2'(k);
      #1 check("R5 active ref", 32'(pinOut[3:0]), 32'(1 << k));
    end
    activeRef = '0;
  endtask

  task automatic testDivider();
    logic prev;
    int n;
    int guard;
    clearAll();
    writeCfg(0, 8'h82);
    @(negedge clk);
    prev = pinOut[0];
    guard = 0;
    while (!(prev == 1'b0 && pinOut[0] == 1'b1) && guard < 80) begin
      prev = pinOut[0];
      @(negedge clk);
      guard++;
    end
    n = 0;
    while (pinOut[0] == 1'b1 && n < 80) begin n++; @(negedge clk); end
    check("R3 div high len", 32'(n), 16);
    n = 0;
    while (pinOut[0] == 1'b0 && n < 80) begin n++; @(negedge clk); end
    check("R3 div low len", 32'(n), 16);
  endtask

  task automatic testRoute();
    clearAll();
    writeCfg(2, 8'd17);
    writeCfg(4, 8'd50);
    writeCfg(6, 8'd69);
    @(negedge clk);
    pinIn = 8'b0101_0100;
    @(negedge clk);
    check("R7 one edge no change", 32'(ctrlOut), 0);
    @(negedge clk);
    check("R7 two edge routed", 32'(ctrlOut), 32'((1 << 6) | (1 << 16) | (1 << 20)));
    pinIn = '0;
    repeat (2) @(negedge clk);
    check("R7 released", 32'(ctrlOut), 0);
  endtask

  task automatic testBoth();
    clearAll();
    writeCfg(3, 8'd68);
    @(negedge clk);
    pinIn = 8'h08;
    repeat (2) @(negedge clk);
    check("R8 code68 both", 32'(ctrlOut), 32'((1 << 18) | (1 << 19)));
    pinIn = '0;
  endtask

  task automatic testPriority();
    clearAll();
    writeCfg(1, 8'd3);
    writeCfg(5, 8'd3);
    @(negedge clk);
    pinIn = 8'h20;
    repeat (2) @(negedge clk);
    check("R9 low pin wins (0)", 32'(ctrlOut), 0);
    pinIn = 8'h02;
    repeat (2) @(negedge clk);
    check("R9 low pin wins (1)", 32'(ctrlOut), 32'(1 << 2));
    writeCfg(1, 8'd64);
    writeCfg(5, 8'd68);
    writeCfg(7, 8'd65);
    pinIn = 8'h20;
    repeat (2) @(negedge clk);
    check("R9 code68 split", 32'(ctrlOut), 32'(1 << 19));
    pinIn = 8'h82;
    repeat (2) @(negedge clk);
    check("R9 high pin blocked", 32'(ctrlOut), 32'(1 << 18));
    pinIn = '0;
  endtask

  task automatic testUnused();
    clearAll();
    writeCfg(0, 8'd6);
    writeCfg(1, 8'd70);
    writeCfg(2, 8'd127);
    writeCfg(3, 8'd21);
    writeCfg(4, 8'h80 | 8'd1);
    writeCfg(5, 8'h80 | 8'd5);
    @(negedge clk);
    pinIn = 8'hFF;
    repeat (3) @(negedge clk);
    check("R10 unused inputs ignored", 32'(ctrlOut), 0);
    check("R2 output pins not routed", 32'(pinOut), 32'h10);
    pinIn = '0;
  endtask

  task automatic testWrite();
    clearAll();
    writeCfg(4, 8'h81);
    check("R11 single write", 32'(pinOe), 32'h10);
    @(negedge clk);
    cfgSel = 3'd6; cfgData = 8'h81; cfgWe = 1'b0;
    @(negedge clk);
    check("R11 no strobe hold", 32'(pinOe), 32'h10);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testConstants();
    testStatus();
    testActiveRef();
    testDivider();
    testRoute();
    testBoth();
    testPriority();
    testUnused();
    testWrite();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule